// File: doc/BRIEF.md
# Sequenced Acquisition Trigger

This block decides when an acquisition trigger fires. It receives single-cycle event pulses from two condition matchers upstream, called the first and second event. It combines them according to a selected mode. The modes are:

- fire on the first event alone;
- fire on the spacing between a first event and a following second event, judged against a lower and an upper bound;
- fire once the first event has been seen a set number of times;
- fire once, after a first event, the second event has been seen a set number of times.

Software sets the mode, the bounds and the count, then pulses `arm_i`. The block then waits for its sequence and emits one `fire_o` pulse, which marks time zero. With that pulse it presents `stamp_o`, the number of ticks from the arm cycle to the event that completed the sequence. After firing it stays idle until it is armed again. One clock cycle is one tick of the interval timer. The tick counters are `TW` bits wide and saturate, and the event counter is `CW` bits wide.

Top module: `trig_seq`

## Requirements
- R1: After reset `fire_o` is 0, `busy_o` is 0 and `stamp_o` is 0.
- R2: A cycle with `arm_i` high makes `busy_o` 1 from the next cycle. While idle, event pulses produce no `fire_o` and leave `busy_o` at 0.
- R3: With `mode_i`=0 (single), a first event in an armed cycle raises `fire_o` for one cycle after that clock edge, and `busy_o` drops to 0.
- R4: With `mode_i`=1 (interval) and `win_i`=0 (short), the elapsed count is the number of cycles from the first-event cycle to the second-event cycle. The block fires when a second event arrives with elapsed < `min_i`. Once elapsed reaches `min_i` with no second event, the block returns to waiting for a first event and stays busy.
- R5: With `mode_i`=1 and `win_i`=1 (window), the block fires when `min_i` <= elapsed <= `max_i`. A second event outside that range returns the block to waiting for a first event.
- R6: With `mode_i`=1 and `win_i`=2 or 3 (long), the block fires when elapsed > `max_i`. Otherwise a second event returns it to waiting for a first event.
- R7: In interval mode, a second event seen before any first event is ignored. A new first event while the block waits for the second event restarts the elapsed count.
- R8: With `mode_i`=2, the block fires on the `count_i`-th first event since arming, and second events are ignored. A `count_i` of 0 acts as 1.
- R9: With `mode_i`=3, a first event opens counting. The block fires on the `count_i`-th second event after that cycle. Second events before or in the opening cycle are not counted.
- R10: `stamp_o` is loaded when the block fires. Its value is the completing event's cycle minus the arm cycle, saturating at 2^TW-1.
- R11: Each sequence gives exactly one `fire_o` pulse. Arming while busy restarts the sequence and clears the event count.
- R12: In interval mode, if a first and a second event arrive in the same cycle while the block waits for the second event, the second event is judged against the running elapsed count. If that does not fire, the first event restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timer tick |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Start or restart a sequence |
| ev1_i | input | 1 | First event pulse |
| ev2_i | input | 1 | Second event pulse |
| mode_i | input | 2 | 0 single, 1 interval, 2 first-event count, 3 second-event count |
| win_i | input | 2 | Interval test: 0 short, 1 window, 2/3 long |
| min_i | input | TW | Lower elapsed bound |
| max_i | input | TW | Upper elapsed bound |
| count_i | input | CW | Event count target |
| fire_o | output | 1 | One-cycle trigger pulse |
| busy_o | output | 1 | Armed and waiting |
| stamp_o | output | TW | Ticks from arm to the completing event |

## Verification
In interval mode, judging a second event and restarting on a first event can both happen in one cycle. The bench provokes this by pulsing both events together while the block waits. In one case the running elapsed count falls inside the window, so the pulse must fire. In the other case it fails the long test, so the pulse must restart the timing, and a later second event fires with an elapsed count measured from the coinciding cycle. A second overlap occurs when re-arming collides with a partly counted sequence; there the count must start again from zero.

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int TW = 32,
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          ev1_i,
  input  logic          ev2_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    win_i,
  input  logic [TW-1:0] min_i,
  input  logic [TW-1:0] max_i,
  input  logic [CW-1:0] count_i,
  output logic          fire_o,
  output logic          busy_o,
  output logic [TW-1:0] stamp_o
);
  localparam logic [TW-1:0] TSAT = '1;
  localparam logic [CW-1:0] CSAT = '1;

  typedef enum logic [1:0] {S_IDLE, S_W1, S_W2} st_t;

  st_t           st, st_n;
  logic [TW-1:0] tmr, age, tmr_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          hit;

  wire [TW-1:0] tmr_inc = (tmr == TSAT) ? tmr : tmr + 1'b1;
  wire [TW-1:0] age_inc = (age == TSAT) ? age : age + 1'b1;
  wire [CW-1:0] cnt_inc = (cnt == CSAT) ? cnt : cnt + 1'b1;
  wire          cnt_hit = cnt_inc >= count_i;
  wire          lo      = tmr < min_i;
  wire          hi      = tmr > max_i;
  wire          dur_ok  = win_i[1] ? hi : (win_i[0] ? (!lo && !hi) : lo);

  assign busy_o = (st != S_IDLE);

  always_comb begin
    st_n  = st;
    tmr_d = tmr_inc;
    cnt_d = cnt;
    hit   = 1'b0;
    case (st)
      S_W1: begin
        case (mode_i)
          2'd0: hit = ev1_i;
          2'd1: if (ev1_i) begin st_n = S_W2; tmr_d = 1; end
          2'd2: if (ev1_i) begin cnt_d = cnt_inc; hit = cnt_hit; end
          default: if (ev1_i) begin st_n = S_W2; cnt_d = '0; end
        endcase
      end
      S_W2: begin
        if (mode_i == 2'd3) begin
          if (ev2_i) begin cnt_d = cnt_inc; hit = cnt_hit; end
        end else if (ev2_i && dur_ok) begin
          hit = 1'b1;
        end else if (ev1_i) begin
          tmr_d = 1;
        end else if (ev2_i || (win_i == 2'd0 && !lo)) begin
          st_n = S_W1;
        end
      end
      default: ;
    endcase
    if (hit) st_n = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; age <= '0; cnt <= '0;
      fire_o <= 1'b0; stamp_o <= '0;
    end else begin
      fire_o <= 1'b0;
      if (arm_i) begin
        st <= S_W1; tmr <= '0; age <= 1; cnt <= '0;
      end else begin
        st <= st_n; tmr <= tmr_d; cnt <= cnt_d; age <= age_inc;
        if (hit) begin
          fire_o  <= 1'b1;
          stamp_o <= age;
        end
      end
    end
  end

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
  a_r11_idle_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> !busy_o);
  a_r3_single_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_W1 && mode_i == 2'd0 && ev1_i && !arm_i) |=> fire_o);
  a_r4_short_below_min: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && $past(mode_i == 2'd1 && win_i == 2'd0)) |-> $past(tmr < min_i));
  a_r8_count_on_ev1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && $past(mode_i == 2'd2)) |-> $past(ev1_i));
  a_r2_arm_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> busy_o);
endmodule

// File: tb/sim_trig_seq.sv
module sim_trig_seq;
  localparam int TW = 8;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, arm_i = 0, ev1_i = 0, ev2_i = 0;
  logic [1:0] mode_i = 0, win_i = 0;
  logic [TW-1:0] min_i = 0, max_i = 0;
  logic [CW-1:0] count_i = 0;
  logic fire_o, busy_o;
  logic [TW-1:0] stamp_o;

  trig_seq #(.TW(TW), .CW(CW)) u0 (.*);

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, arm_cyc = 0;
  int    q_cyc[$], q_stamp[$];
  string q_tag[$];
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (fire_o) begin
      if (q_cyc.size() == 0) chk(0, "unexpected fire R2/R11", 1, 0);
      else begin
        chk(q_cyc[0] == cyc, {q_tag[0], " fire cycle"}, cyc, q_cyc[0]);
        chk(stamp_o == q_stamp[0], {q_tag[0], " stamp R10"}, stamp_o, q_stamp[0]);
        void'(q_cyc.pop_front()); void'(q_stamp.pop_front()); void'(q_tag.pop_front());
      end
    end else if (q_cyc.size() != 0 && q_cyc[0] <= cyc) begin
      chk(0, {q_tag[0], " missing fire"}, 0, 1);
      void'(q_cyc.pop_front()); void'(q_stamp.pop_front()); void'(q_tag.pop_front());
    end
  end

  task automatic drive(input logic a, input logic e1, input logic e2);
    arm_i = a; ev1_i = e1; ev2_i = e2;
    @(negedge clk);
    arm_i = 0; ev1_i = 0; ev2_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(0, 0, 0);
  endtask

  task automatic do_arm;
    arm_cyc = cyc;
    drive(1, 0, 0);
  endtask

  task automatic fire_ev(input logic e1, input logic e2, input string tag);
    int s;
    s = cyc - arm_cyc;
    if (s > 255) s = 255;
    q_cyc.push_back(cyc + 1); q_stamp.push_back(s); q_tag.push_back(tag);
    drive(0, e1, e2);
  endtask

  task automatic cfg(input int m, input int w, input int mn, input int mx, input int c);
    mode_i = m[1:0]; win_i = w[1:0]; min_i = mn[TW-1:0]; max_i = mx[TW-1:0]; count_i = c[CW-1:0];
  endtask

  task automatic finish_run;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fire_o == 0 && busy_o == 0 && stamp_o == 0, "R1 reset", {fire_o, busy_o}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 idle ignores events
    cfg(0, 0, 0, 0, 1);
    drive(0, 1, 1); idle(1);
    chk(busy_o == 0, "R2 idle busy", busy_o, 0);
    do_arm;
    chk(busy_o == 1, "R2 armed busy", busy_o, 1);
    // R3 single
    idle(2); fire_ev(1, 0, "R3");
    chk(busy_o == 0, "R3 idle after fire", busy_o, 0);
    drive(0, 1, 0); idle(2);  // R11 no second pulse
    // R4 short
    cfg(1, 0, 5, 0, 1);
    do_arm; drive(0, 1, 0); idle(2); fire_ev(0, 1, "R4 short fire");
    do_arm; drive(0, 1, 0); idle(6); drive(0, 0, 1); idle(1);
    chk(busy_o == 1, "R4 abandon still busy", busy_o, 1);
    drive(0, 1, 0); fire_ev(0, 1, "R4 after abandon");
    // R5 window
    cfg(1, 1, 3, 5, 1);
    do_arm; drive(0, 1, 0); idle(2); fire_ev(0, 1, "R5 at min");
    do_arm; drive(0, 1, 0); idle(4); fire_ev(0, 1, "R5 at max");
    do_arm; drive(0, 1, 0); idle(5); drive(0, 0, 1);
    drive(0, 1, 0); idle(1); drive(0, 0, 1); idle(1);
    chk(busy_o == 1, "R5 outside no fire", busy_o, 1);
    // R6 long
    cfg(1, 2, 0, 4, 1);
    do_arm; drive(0, 1, 0); idle(3); drive(0, 0, 1);
    drive(0, 1, 0); idle(4); fire_ev(0, 1, "R6 long");
    // R7 restart and early second event
    cfg(1, 0, 5, 0, 1);
    do_arm; drive(0, 0, 1);
    chk(busy_o == 1, "R7 early ev2 ignored", busy_o, 1);
    drive(0, 1, 0); idle(3); drive(0, 1, 0); idle(3); fire_ev(0, 1, "R7 restart");
    // R12 coinciding events
    cfg(1, 1, 2, 3, 1);
    do_arm; drive(0, 1, 0); idle(1); fire_ev(1, 1, "R12 judged first");
    cfg(1, 2, 0, 3, 1);
    do_arm; drive(0, 1, 0); idle(1); drive(0, 1, 1); idle(3); fire_ev(0, 1, "R12 restart");
    // R8 first-event count
    cfg(2, 0, 0, 0, 3);
    do_arm; drive(0, 1, 0); drive(0, 0, 1); drive(0, 1, 0); fire_ev(1, 0, "R8 third");
    cfg(2, 0, 0, 0, 0);
    do_arm; fire_ev(1, 0, "R8 zero as one");
    // R9 second-event count
    cfg(3, 0, 0, 0, 2);
    do_arm; drive(0, 0, 1); drive(0, 1, 1); drive(0, 0, 1); fire_ev(0, 1, "R9 second ev2");
    // R11 re-arm while busy
    cfg(2, 0, 0, 0, 2);
    do_arm; drive(0, 1, 0); do_arm; drive(0, 1, 0); fire_ev(1, 0, "R11 rearm");
    // R10 saturation
    cfg(0, 0, 0, 0, 1);
    do_arm; idle(300); fire_ev(1, 0, "R10 saturate");
    idle(4);
    chk(q_cyc.size() == 0, "pending expected fires", q_cyc.size(), 0);
    finish_run();
  end
endmodule